// File: doc/BRIEF.md
# External Interrupt Controller

This block collects eight external request lines and turns them into one interrupt request for a processor, with the index of the winning line. Each line has its own two-bit sense setting: low level, any change, falling edge or rising edge. It also has a mask bit and, for the edge-style settings, a pending flag. A single global enable gates every request. The pins pass through a two-flop synchronizer before any detection, so detection works from the pin value alone and ignores pad direction. Software that drives its own output pin can therefore raise an interrupt.

Software reaches the block through a single-cycle register port. Writes commit on the clock edge. Reads are combinational from the address. On the processor side, an acknowledge strobe takes the current request. It clears the global enable, and for an edge-style line it clears that line's flag. A return strobe sets the global enable again. Software may set the enable inside a handler to allow nesting. A low-level line latches nothing: it requests only while the synchronized pin is low. Software changing a sense field is expected to first clear the mask bit, then write the field, then clear the flag with a 1, then restore the mask bit.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, the global enable, the mask register, both sense registers and the flag register all read 0, and `irq_req` is low.
- R2: While the global enable is 0, `irq_req` stays low whatever the masks and flags hold. Flags still latch events in that state.
- R3: A line raises `irq_req` only when its own mask bit is 1. A pending flag on a masked-off line produces no request.
- R4: The sense code for line n selects its event: 01 = any change, 10 = falling edge, 11 = rising edge. An event sets flag n. A transition of the other polarity does not.
- R5: A set flag holds while requests are blocked by the mask or the global enable. It produces a request as soon as the blocking is removed.
- R6: Sense code 00 (low level) latches no flag. The request lasts only while the synchronized pin is low, so a low that ends before service is lost.
- R7: A write to the flag register clears each flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged.
- R8: When `irq_ack` is high while `irq_req` is high, the next cycle has the global enable cleared and the winning line's flag cleared. `irq_ret` sets the global enable. A software write of 1 to the enable bit inside a handler also sets it.
- R9: When several lines request at once, the lowest-numbered one wins, and `irq_vec` reports its number.
- R10: A pin change driven between clock edges shows as a set flag after the third rising edge. A low level shows as a request after the second rising edge.
- R11: The register map is: address 0 is the enable in bit 0; address 1 is the mask (bit n = line n); address 2 holds the sense codes of lines 0..3 and address 3 those of lines 4..7, with line n in bits 2(n mod 4)+1 : 2(n mod 4); address 4 is the flag register; address 5 reads the synchronized pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ext_pin | input | 8 | Raw external request lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from address |
| irq_ack | input | 1 | Processor takes the current request |
| irq_ret | input | 1 | Processor returns from a handler |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_vec | output | 3 | Number of the winning line |

## Verification
The assertions assume that `irq_ack` is only meaningful while `irq_req` is high. They also assume that pins change slowly enough for the synchronizer to see every level for at least one clock. The stimulus changes pins only between clock edges and holds each level for several cycles. It pulses the acknowledge only while a request is known to be pending. The bench never strobes `irq_ack` and `irq_ret` in the same cycle, so the ordering of the enable updates stays unambiguous.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int DW = 8;
  localparam int AW = 3;

  typedef enum logic [1:0] {
    SNS_LOW  = 2'b00,
    SNS_ANY  = 2'b01,
    SNS_FALL = 2'b10,
    SNS_RISE = 2'b11
  } sense_e;

  localparam logic [AW-1:0] ADR_CTRL  = 3'd0;
  localparam logic [AW-1:0] ADR_MASK  = 3'd1;
  localparam logic [AW-1:0] ADR_SENSE = 3'd2;
  localparam logic [AW-1:0] ADR_FLAG  = 3'd4;
  localparam logic [AW-1:0] ADR_PIN   = 3'd5;

  // event test for one line: current and previous synchronized samples
  function automatic logic edge_hit(sense_e m, logic cur, logic prev);
    case (m)
      SNS_ANY:  return cur ^ prev;
      SNS_FALL: return prev & ~cur;
      SNS_RISE: return cur & ~prev;
      default:  return 1'b0;
    endcase
  endfunction

  // level request for one line
  function automatic logic level_hit(sense_e m, logic cur);
    return (m == SNS_LOW) & ~cur;
  endfunction
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int N      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] cur_o,
  output logic [N-1:0] prev_o
);
  localparam int CHAIN = STAGES + 1;

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [CHAIN-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[CHAIN-2:0], pin_i[g]};
    end
    assign cur_o[g]  = chain_q[STAGES-1];
    assign prev_o[g] = chain_q[STAGES];
  end
endmodule

// File: rtl/eic_line.sv
module eic_line
  import eic_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  sense_e mode_i,
  input  logic   cur_i,
  input  logic   prev_i,
  input  logic   w1c_i,
  input  logic   ack_clr_i,
  output logic   evt_o,
  output logic   lvl_o,
  output logic   flag_o
);
  assign evt_o = edge_hit(mode_i, cur_i, prev_i);
  assign lvl_o = level_hit(mode_i, cur_i);

  // a fresh event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    flag_o <= 1'b0;
    else if (evt_o)                flag_o <= 1'b1;
    else if (w1c_i || ack_clr_i)   flag_o <= 1'b0;
  end

  assert_edge_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |=> flag_o);
  assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !w1c_i && !ack_clr_i) |=> flag_o);
  assert_level_noflag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_o && mode_i == SNS_LOW) |=> !flag_o);
  assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (w1c_i && !evt_o) |=> !flag_o);
endmodule

// File: rtl/eic_prio.sv
module eic_prio #(
  parameter int N  = 8,
  parameter int VW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  output logic          req_o,
  output logic [VW-1:0] vec_o
);
  function automatic logic [N-1:0] below(logic [VW-1:0] v);
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) m[i] = (i < int'(v));
    return m;
  endfunction

  always_comb begin
    vec_o = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req_i[i]) vec_o = VW'(i);
  end
  assign req_o = |req_i;

  assert_lowest_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (req_i[vec_o] && ((req_i & below(vec_o)) == '0)));
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eic_pkg::*;
#(
  parameter int N  = 8,
  parameter int VW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  ext_pin,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          irq_ack,
  input  logic          irq_ret,
  output logic          irq_req,
  output logic [VW-1:0] irq_vec
);
  localparam int PER_BANK = DW / 2;
  localparam int NBANK    = N / PER_BANK;

  logic           gie_q;
  logic [N-1:0]   mask_q;
  logic [2*N-1:0] sense_q;
  logic [N-1:0]   cur_w, prev_w, evt_w, lvl_w, flag_w;
  logic [N-1:0]   w1c_w, ack_clr_w, active_w;
  logic           ack_fire_w;

  eic_sync #(.N(N), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(ext_pin), .cur_o(cur_w), .prev_o(prev_w)
  );

  assign ack_fire_w = irq_ack && irq_req;
  assign w1c_w = (reg_we && reg_addr == ADR_FLAG) ? reg_wdata[N-1:0] : '0;

  for (genvar g = 0; g < N; g++) begin : g_line
    assign ack_clr_w[g] = ack_fire_w && (irq_vec == VW'(g));
    eic_line u_line (
      .clk(clk), .rst_n(rst_n),
      .mode_i(sense_e'(sense_q[2*g +: 2])),
      .cur_i(cur_w[g]), .prev_i(prev_w[g]),
      .w1c_i(w1c_w[g]), .ack_clr_i(ack_clr_w[g]),
      .evt_o(evt_w[g]), .lvl_o(lvl_w[g]), .flag_o(flag_w[g])
    );
  end

  assign active_w = (flag_w | lvl_w) & mask_q & {N{gie_q}};

  eic_prio #(.N(N), .VW(VW)) u_prio (
    .clk(clk), .rst_n(rst_n), .req_i(active_w), .req_o(irq_req), .vec_o(irq_vec)
  );

  // global enable: acknowledge beats return beats software write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                gie_q <= 1'b0;
    else if (ack_fire_w)                       gie_q <= 1'b0;
    else if (irq_ret)                          gie_q <= 1'b1;
    else if (reg_we && reg_addr == ADR_CTRL)   gie_q <= reg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              mask_q <= '0;
    else if (reg_we && reg_addr == ADR_MASK) mask_q <= reg_wdata[N-1:0];
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sense_q[b*DW +: DW] <= '0;
      else if (reg_we && reg_addr == AW'(int'(ADR_SENSE) + b))
        sense_q[b*DW +: DW] <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADR_CTRL:      reg_rdata[0] = gie_q;
      ADR_MASK:      reg_rdata[N-1:0] = mask_q;
      ADR_SENSE:     reg_rdata = sense_q[0 +: DW];
      ADR_SENSE + 1: reg_rdata = sense_q[DW +: DW];
      ADR_FLAG:      reg_rdata[N-1:0] = flag_w;
      ADR_PIN:       reg_rdata[N-1:0] = cur_w;
      default:       reg_rdata = '0;
    endcase
  end

  assert_no_req_gie_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_q |-> !irq_req);
  assert_ack_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire_w |=> (!gie_q && !irq_req));
  assert_ret_enables_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && !ack_fire_w) |=> gie_q);
  assert_masked_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> mask_q[irq_vec]);
endmodule

// File: tb/ext_irq_ctrl_tb.sv
module ext_irq_ctrl_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] ext_pin = 8'hFF;
  logic       reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       irq_ack = 0, irq_ret = 0, irq_req;
  logic [2:0] irq_vec;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] rd;
    logic       req;
    logic [2:0] vec;
    string      rid;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  ext_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  // monitor: pops expected items and compares at the falling edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_chk++;
      if (reg_rdata !== it.rd || irq_req !== it.req ||
          (it.req && irq_vec !== it.vec)) begin
        n_fail++;
        $display("FAIL %s: rdata=%h req=%b vec=%0d expected rdata=%h req=%b vec=%0d",
                 it.rid, reg_rdata, irq_req, irq_vec, it.rd, it.req, it.vec);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic obs(input logic [2:0] a, input logic [7:0] rd,
                     input logic req, input logic [2:0] vec, input string rid);
    item_t it;
    reg_addr = a;
    it.rd = rd; it.req = req; it.vec = vec; it.rid = rid;
    sb_q.push_back(it);
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 0;
  endtask

  task automatic ack();
    irq_ack = 1; @(posedge clk); #1; irq_ack = 0;
  endtask

  task automatic ret();
    irq_ret = 1; @(posedge clk); #1; irq_ret = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3); rst_n = 1; tick(3);
    // R1 reset state, R11 map
    obs(0, 8'h00, 0, 0, "R1 enable");
    obs(1, 8'h00, 0, 0, "R1 mask");
    obs(2, 8'h00, 0, 0, "R1 sense");
    obs(4, 8'h00, 0, 0, "R1 flags");
    obs(5, 8'hFF, 0, 0, "R11 pins");
    // line0 fall, line1 rise, line2 any, line3 level; lines 4..7 fall
    wr(2, 8'h1E); wr(3, 8'hAA);
    obs(2, 8'h1E, 0, 0, "R11 sense lo");
    obs(3, 8'hAA, 0, 0, "R11 sense hi");
    ext_pin = 8'hFE; tick(3); obs(4, 8'h01, 0, 0, "R4 fall sets, R2 no req");
    ext_pin = 8'hFF; tick(3); obs(4, 8'h01, 0, 0, "R4 rise ignored on fall line");
    ext_pin = 8'hFD; tick(3); obs(4, 8'h01, 0, 0, "R4 fall ignored on rise line");
    ext_pin = 8'hFF; tick(3); obs(4, 8'h03, 0, 0, "R4 rise sets");
    ext_pin = 8'hFB; tick(3); obs(4, 8'h07, 0, 0, "R4 any change fall");
    wr(4, 8'h04); obs(4, 8'h03, 0, 0, "R7 write one clears");
    wr(4, 8'h00); obs(4, 8'h03, 0, 0, "R7 write zero keeps");
    ext_pin = 8'hFF; tick(3); obs(4, 8'h07, 0, 0, "R4 any change rise");
    wr(4, 8'h07); obs(4, 8'h00, 0, 0, "R7 clear all");
    // masks and enable
    wr(1, 8'h02); wr(0, 8'h01);
    ext_pin = 8'hFE; tick(3); obs(4, 8'h01, 0, 0, "R3 masked flag no req");
    wr(1, 8'h03); obs(1, 8'h03, 1, 0, "R5 pending served on unmask");
    wr(0, 8'h00); obs(4, 8'h01, 0, 0, "R2 enable off blocks");
    wr(0, 8'h01); obs(0, 8'h01, 1, 0, "R5 served on enable");
    ext_pin = 8'hFF; tick(3);
    ack(); obs(0, 8'h00, 0, 0, "R8 ack clears enable");
    obs(4, 8'h00, 0, 0, "R8 ack clears flag");
    ret(); obs(0, 8'h01, 0, 0, "R8 return sets enable");
    wr(1, 8'hFF); obs(1, 8'hFF, 0, 0, "R3 mask all, nothing pending");
    // priority lines 2 and 4
    ext_pin = 8'hEB; tick(3); obs(4, 8'h14, 1, 2, "R9 lowest wins");
    ack(); obs(4, 8'h10, 0, 0, "R8 only winner cleared");
    ret(); obs(4, 8'h10, 1, 4, "R9 next line served");
    ack(); obs(4, 8'h00, 0, 0, "R8 flag cleared");
    wr(0, 8'h01); obs(0, 8'h01, 0, 0, "R8 software nesting enable");
    ext_pin = 8'hFF; tick(3); obs(4, 8'h04, 1, 2, "R4 any change on release");
    ack(); ret();
    // level line 3
    ext_pin = 8'hF7; tick(1); obs(4, 8'h00, 0, 0, "R10 level not yet");
    tick(1); obs(4, 8'h00, 1, 3, "R6 level request no flag");
    tick(5); obs(4, 8'h00, 1, 3, "R6 level held");
    ack(); obs(0, 8'h00, 0, 0, "R8 ack on level line");
    ext_pin = 8'hFF; tick(2); ret(); obs(4, 8'h00, 0, 0, "R6 released level lost");
    // edge latency line 5
    ext_pin = 8'hDF; tick(2); obs(4, 8'h00, 0, 0, "R10 edge not yet");
    tick(1); obs(4, 8'h20, 1, 5, "R10 edge on third edge");
    ack(); ext_pin = 8'hFF; tick(3); ret();
    // level line 3 against edge line 6
    ext_pin = 8'hB7; tick(3); obs(4, 8'h40, 1, 3, "R9 level line outranks");
    ext_pin = 8'hFF; tick(2); obs(4, 8'h40, 1, 6, "R9 edge line after level gone");
    ack(); obs(4, 8'h00, 0, 0, "R8 final ack");
    tick(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule